// File: doc/BRIEF.md
# IPv4 Header Fast-Path Checker and Updater

This block sits after a header request queue in a forwarding path. Each entry it takes is 32 bytes. The first 8 bytes are a link-layer descriptor and the remaining bytes are the leading part of the IPv4 header. The block decides whether the datagram can be forwarded on the fast path. A fast header leaves with its TTL lowered by one and its header checksum adjusted by ones'-complement incremental arithmetic. The existing checksum is never verified, so a header that arrived with a wrong checksum still carries a wrong one. Any other header leaves unchanged, marked for the slow path, with a reason code.

The block holds one header at a time in a single output register and accepts a new entry only while that register is empty. Route lookup happens elsewhere. For every header the block presents the IPv4 destination address, which a lookup stage can use. The outgoing MTU is a configuration input, and it is compared with the total length field.

Top module: `ipfp_hdr_proc`

## Requirements
- R1: During reset and after an asynchronous reset, out_valid is 0. in_ready is 1 once reset has been released and synchronised.
- R2: An entry is taken on a clock edge with in_valid and in_ready both 1, and the result appears with out_valid 1 on the next cycle. in_ready is 1 only while out_valid is 0. While out_ready is 0, every output holds its value and no new entry is taken.
- R3: Reason 1 (not IP) is given when descriptor bytes 6..7 (entry bytes 6 and 7, big-endian) are not 0x0800, or when the version nibble (high nibble of entry byte 8) is not 4.
- R4: Reason 2 (bad length) is given when the header length nibble (low nibble of entry byte 8) is below 5, or when total length (entry bytes 10..11) is below 20.
- R5: Reason 3 (options) is given when the header length nibble is above 5.
- R6: Reason 4 (multicast) is given when the top four bits of the destination (entry bytes 24..27) are 1110.
- R7: Reason 5 (fragmentation needed) is given when total length is greater than cfg_mtu. A total length equal to cfg_mtu is not a cause.
- R8: Reason 6 (TTL expired) is given when TTL (entry byte 16) is 0 or 1, and the TTL is not decremented.
- R9: When several causes apply, the lowest reason code is reported.
- R10: With no cause, out_fast is 1 and out_reason is 0. TTL is lowered by one and the checksum (entry bytes 18..19) is updated incrementally, so the ones'-complement sum of the ten header words (entry bytes 8..27) is unchanged. All other bytes are unchanged.
- R11: The checksum is not verified. A header with a wrong checksum still takes the fast path, and its header word sum keeps the same wrong value.
- R12: A slow-path header leaves with out_fast 0 and the entry bit for bit unchanged.
- R13: out_dst equals the destination address of the held entry on every header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An entry is offered |
| in_ready | output | 1 | The block can take an entry |
| in_hdr | input | 256 | Entry: byte 0 in bits 255:248 |
| cfg_mtu | input | 16 | Outgoing MTU in bytes |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | Downstream takes the result |
| out_hdr | output | 256 | Rewritten or unchanged entry |
| out_fast | output | 1 | 1 for the fast path |
| out_reason | output | 3 | 0 fast, 1 not IP, 2 bad length, 3 options, 4 multicast, 5 fragmentation needed, 6 TTL expired |
| out_dst | output | 32 | Destination address for lookup |

## Verification
Classification and rewriting are decided in the same cycle. Several slow-path causes can also be present in one header. Vectors are built with up to four causes at once, for example options with multicast, over-MTU length and a TTL of 1. The reported code is judged against the lowest applicable code, and the entry is checked to leave unchanged. For fast headers, the rewrite is judged by summing the header words independently in the bench. The result must equal the sum of the input, both for headers with a correct checksum and for headers with a wrong one.

// File: rtl/ipfp_pkg.sv
package ipfp_pkg;
  localparam int TLEN_W = 16;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [TLEN_W-1:0] MIN_TLEN = 16'd20;
  localparam logic [3:0] BASE_IHL = 4'd5;
  localparam logic [3:0] MCAST_TOP = 4'hE;

  typedef enum logic [2:0] {
    RSN_FAST    = 3'd0,
    RSN_NOT_IP  = 3'd1,
    RSN_BAD_LEN = 3'd2,
    RSN_OPTIONS = 3'd3,
    RSN_MCAST   = 3'd4,
    RSN_FRAG    = 3'd5,
    RSN_TTL     = 3'd6
  } reason_e;
endpackage

// File: rtl/ipfp_rst_sync.sv
module ipfp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/ipfp_classify.sv
module ipfp_classify
  import ipfp_pkg::*;
(
  input  logic [15:0]       etype,
  input  logic [3:0]        ver,
  input  logic [3:0]        ihl,
  input  logic [TLEN_W-1:0] tlen,
  input  logic [7:0]        ttl,
  input  logic [3:0]        dst_top,
  input  logic [TLEN_W-1:0] mtu,
  output reason_e           reason
);
  always_comb begin
    if (etype != ETYPE_IPV4 || ver != 4'd4)   reason = RSN_NOT_IP;
    else if (ihl < BASE_IHL || tlen < MIN_TLEN) reason = RSN_BAD_LEN;
    else if (ihl > BASE_IHL)                  reason = RSN_OPTIONS;
    else if (dst_top == MCAST_TOP)            reason = RSN_MCAST;
    else if (tlen > mtu)                      reason = RSN_FRAG;
    else if (ttl <= 8'd1)                     reason = RSN_TTL;
    else                                      reason = RSN_FAST;
  end
endmodule

// File: rtl/ipfp_csum_upd.sv
module ipfp_csum_upd (
  input  logic [15:0] old_ck,
  input  logic [15:0] old_word,
  input  logic [15:0] new_word,
  output logic [15:0] new_ck
);
  logic [17:0] raw_sum;
  logic [16:0] fold1;
  logic [16:0] fold2;

  always_comb begin
    raw_sum = {2'b00, ~old_ck} + {2'b00, ~old_word} + {2'b00, new_word};
    fold1   = {1'b0, raw_sum[15:0]} + {15'd0, raw_sum[17:16]};
    fold2   = {1'b0, fold1[15:0]} + {16'd0, fold1[16]};
    new_ck  = ~fold2[15:0];
  end
endmodule

// File: rtl/ipfp_hdr_proc.sv
module ipfp_hdr_proc
  import ipfp_pkg::*;
#(
  parameter int ENTRY_BYTES = 32,
  parameter int DESC_BYTES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ENTRY_BYTES*8-1:0] in_hdr,
  input  logic [TLEN_W-1:0]        cfg_mtu,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ENTRY_BYTES*8-1:0] out_hdr,
  output logic                     out_fast,
  output logic [2:0]               out_reason,
  output logic [31:0]              out_dst
);
  localparam int ENTRY_W   = ENTRY_BYTES * 8;
  localparam int TOP       = ENTRY_W - 1;
  localparam int ETYPE_MSB = TOP - 8 * (DESC_BYTES - 2);
  localparam int VER_MSB   = TOP - 8 * DESC_BYTES;
  localparam int TLEN_MSB  = TOP - 8 * (DESC_BYTES + 2);
  localparam int TTL_MSB   = TOP - 8 * (DESC_BYTES + 8);
  localparam int PROTO_MSB = TOP - 8 * (DESC_BYTES + 9);
  localparam int CK_MSB    = TOP - 8 * (DESC_BYTES + 10);
  localparam int DST_MSB   = TOP - 8 * (DESC_BYTES + 16);

  logic        rst_int_n;
  reason_e     reason;
  logic [7:0]  ttl_in;
  logic [7:0]  ttl_dec;
  logic [15:0] ck_new;
  logic [ENTRY_W-1:0] hdr_rw;

  logic               valid_q, valid_d;
  logic [ENTRY_W-1:0] hdr_q, hdr_d;
  logic               fast_q, fast_d;
  reason_e            reason_q, reason_d;
  logic [31:0]        dst_q, dst_d;
  logic               load, drain;

  ipfp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_int_n)
  );

  assign ttl_in  = in_hdr[TTL_MSB -: 8];
  assign ttl_dec = ttl_in - 8'd1;

  ipfp_classify u_cls (
    .etype  (in_hdr[ETYPE_MSB -: 16]),
    .ver    (in_hdr[VER_MSB -: 4]),
    .ihl    (in_hdr[VER_MSB-4 -: 4]),
    .tlen   (in_hdr[TLEN_MSB -: TLEN_W]),
    .ttl    (ttl_in),
    .dst_top(in_hdr[DST_MSB -: 4]),
    .mtu    (cfg_mtu),
    .reason (reason)
  );

  ipfp_csum_upd u_ck (
    .old_ck  (in_hdr[CK_MSB -: 16]),
    .old_word({ttl_in, in_hdr[PROTO_MSB -: 8]}),
    .new_word({ttl_dec, in_hdr[PROTO_MSB -: 8]}),
    .new_ck  (ck_new)
  );

  always_comb begin
    hdr_rw = in_hdr;
    hdr_rw[TTL_MSB -: 8] = ttl_dec;
    hdr_rw[CK_MSB -: 16] = ck_new;
  end

  assign load  = in_valid & in_ready;
  assign drain = valid_q & out_ready;

  // next-state process
  always_comb begin
    valid_d  = valid_q;
    hdr_d    = hdr_q;
    fast_d   = fast_q;
    reason_d = reason_q;
    dst_d    = dst_q;
    if (load) begin
      valid_d  = 1'b1;
      fast_d   = (reason == RSN_FAST);
      hdr_d    = (reason == RSN_FAST) ? hdr_rw : in_hdr;
      reason_d = reason;
      dst_d    = in_hdr[DST_MSB -: 32];
    end else if (drain) begin
      valid_d  = 1'b0;
    end
  end

  // register process: valid bit is reset, payload uses an explicit enable
  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) valid_q <= 1'b0;
    else            valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (load) begin
      hdr_q    <= hdr_d;
      fast_q   <= fast_d;
      reason_q <= reason_d;
      dst_q    <= dst_d;
    end
  end

  assign in_ready   = rst_int_n & ~valid_q;
  assign out_valid  = valid_q;
  assign out_hdr    = hdr_q;
  assign out_fast   = fast_q;
  assign out_reason = reason_q;
  assign out_dst    = dst_q;
endmodule

// File: rtl/ipfp_hdr_chk.sv
module ipfp_hdr_chk #(
  parameter int ENTRY_BYTES = 32,
  parameter int DESC_BYTES  = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [ENTRY_BYTES*8-1:0] in_hdr,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [ENTRY_BYTES*8-1:0] out_hdr,
  input logic                     out_fast,
  input logic [2:0]               out_reason,
  input logic [31:0]              out_dst
);
  localparam int TOP     = ENTRY_BYTES * 8 - 1;
  localparam int TTL_MSB = TOP - 8 * (DESC_BYTES + 8);
  localparam int DST_MSB = TOP - 8 * (DESC_BYTES + 16);

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid && in_ready |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_reason) && $stable(out_dst));

  // R2
  no_take_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid |-> !in_ready);

  // R12
  slow_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid && in_ready |=> out_fast || out_hdr == $past(in_hdr));

  // R10
  fast_ttl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid && in_ready |=> !out_fast || out_hdr[TTL_MSB -: 8] == $past(in_hdr[TTL_MSB -: 8]) - 8'd1);

  // R8
  ttl_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid && out_fast |-> out_hdr[TTL_MSB -: 8] != 8'd0 && out_reason == 3'd0);

  // R13
  dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid && in_ready |=> out_dst == $past(in_hdr[DST_MSB -: 32]));
endmodule

bind ipfp_hdr_proc ipfp_hdr_chk #(.ENTRY_BYTES(ENTRY_BYTES), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid(in_valid), .in_ready(in_ready),
  .in_hdr(in_hdr), .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
  .out_fast(out_fast), .out_reason(out_reason), .out_dst(out_dst)
);

// File: tb/sim_ipfp_hdr_proc.sv
module sim_ipfp_hdr_proc;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         in_valid, in_ready, out_valid, out_ready, out_fast;
  logic [255:0] in_hdr, out_hdr;
  logic [15:0]  cfg_mtu;
  logic [2:0]   out_reason;
  logic [31:0]  out_dst;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ipfp_hdr_proc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .cfg_mtu(cfg_mtu), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_fast(out_fast), .out_reason(out_reason), .out_dst(out_dst)
  );

  typedef struct packed {
    logic [15:0] mtu; logic [15:0] et; logic [3:0] ver; logic [3:0] ihl;
    logic [15:0] tlen; logic [7:0] ttl; logic [31:0] dst;
    logic bad; logic prio; logic [2:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd60,   8'd64,  32'hC0A80001, 1'b0, 1'b0, 3'd0},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd1500, 8'd2,   32'h0A0B0C0D, 1'b0, 1'b0, 3'd0},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd20,   8'd255, 32'h01020304, 1'b1, 1'b0, 3'd0},
    '{16'd1500, 16'h86DD, 4'd4, 4'd5, 16'd60,   8'd64,  32'h0A000002, 1'b0, 1'b0, 3'd1},
    '{16'd1500, 16'h0800, 4'd6, 4'd5, 16'd60,   8'd64,  32'h0A000003, 1'b0, 1'b0, 3'd1},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd19,   8'd64,  32'h0A000004, 1'b0, 1'b0, 3'd2},
    '{16'd1500, 16'h0800, 4'd4, 4'd4, 16'd60,   8'd64,  32'h0A000005, 1'b0, 1'b0, 3'd2},
    '{16'd1500, 16'h0800, 4'd4, 4'd6, 16'd60,   8'd64,  32'h0A000006, 1'b0, 1'b0, 3'd3},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd60,   8'd64,  32'hE0000001, 1'b0, 1'b0, 3'd4},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd1501, 8'd64,  32'h0A000007, 1'b0, 1'b0, 3'd5},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd60,   8'd1,   32'h0A000008, 1'b0, 1'b0, 3'd6},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd60,   8'd0,   32'h0A000009, 1'b0, 1'b0, 3'd6},
    '{16'd1500, 16'h0800, 4'd4, 4'd6, 16'd1600, 8'd1,   32'hE1020304, 1'b0, 1'b1, 3'd3},
    '{16'd576,  16'h0800, 4'd4, 4'd5, 16'd600,  8'd0,   32'hEF000001, 1'b0, 1'b1, 3'd4},
    '{16'd576,  16'h0800, 4'd4, 4'd5, 16'd600,  8'd1,   32'h0A00000A, 1'b0, 1'b1, 3'd5},
    '{16'd1500, 16'h86DD, 4'd7, 4'd3, 16'd10,   8'd0,   32'hE0000009, 1'b0, 1'b1, 3'd1},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd60,   8'd128, 32'hDFFFFFFF, 1'b0, 1'b0, 3'd0},
    '{16'd1500, 16'h0800, 4'd4, 4'd5, 16'd60,   8'd64,  32'hF0000001, 1'b0, 1'b0, 3'd0}
  };

  localparam logic [255:0] CK_MASK = ~(256'hFFFF << 96);

  function automatic logic [15:0] osum(input logic [255:0] h);
    logic [31:0] s = 32'd0;
    for (int i = 0; i < 10; i++) s = s + {16'd0, h[191-16*i -: 16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic logic [255:0] build(input vec_t v);
    logic [255:0] h;
    h = {48'hA1A2A3A4A5A6, v.et, v.ver, v.ihl, 8'h00, v.tlen, 16'h1234, 16'h4000,
         v.ttl, 8'h11, 16'h0000, 32'h0A000001, v.dst, 32'hDEADBEEF};
    h[111:96] = ~osum(h);
    if (v.bad) h[111:96] = h[111:96] ^ 16'h0101;
    return h;
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.prio) return "R9";
    if (v.bad)  return "R11";
    case (v.exp)
      3'd0: return "R10";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [255:0] h, input logic [15:0] mtu);
    @(negedge clk_i);
    in_hdr = h; cfg_mtu = mtu; in_valid = 1'b1;
    @(negedge clk_i);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(negedge clk_i);
    out_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    logic [255:0] h, e, h2, held;
    rst_ni = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_hdr = '0; cfg_mtu = 16'd1500;
    #1;
    chk(out_valid == 1'b0, "R1", {255'd0, out_valid}, 256'd0);
    do_reset();
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {254'd0, out_valid, in_ready}, 256'd1);

    for (int i = 0; i < NV; i++) begin
      h = build(VECS[i]);
      offer(h, VECS[i].mtu);
      chk(out_valid == 1'b1 && in_ready == 1'b0, "R2", {254'd0, out_valid, in_ready}, 256'd2);
      chk(out_reason == VECS[i].exp && out_fast == (VECS[i].exp == 3'd0), tag_of(VECS[i]),
          {252'd0, out_fast, out_reason}, {252'd0, VECS[i].exp == 3'd0, VECS[i].exp});
      chk(out_dst == VECS[i].dst, "R13", {224'd0, out_dst}, {224'd0, VECS[i].dst});
      if (VECS[i].exp == 3'd0) begin
        e = h; e[127:120] = h[127:120] - 8'd1;
        chk(((out_hdr & CK_MASK) == (e & CK_MASK)) && osum(out_hdr) == osum(h),
            VECS[i].bad ? "R11" : "R10", out_hdr, e);
      end else begin
        chk(out_hdr == h, VECS[i].exp == 3'd6 ? "R8" : "R12", out_hdr, h);
      end
      drain();
    end

    // back-pressure: result held, second entry refused until drained
    h  = build(VECS[0]);
    h2 = build(VECS[8]);
    offer(h, 16'd1500);
    held = out_hdr;
    @(negedge clk_i);
    in_hdr = h2; in_valid = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(out_valid && !in_ready && out_hdr == held && out_dst == 32'hC0A80001, "R2",
        out_hdr, held);
    in_valid = 1'b0;
    drain();
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R2", {254'd0, out_valid, in_ready}, 256'd1);

    // reset while a result is held
    offer(h, 16'd1500);
    rst_ni = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1", {255'd0, out_valid}, 256'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {254'd0, out_valid, in_ready}, 256'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule